// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave-side protocol engine of a 1 KiB serial EEPROM reached over a four-wire SPI link in mode 0. It runs on a fast system clock and oversamples chip select, serial clock and serial data in through a synchronizer. It takes in an 8-bit instruction, MSB first, and then a 16-bit address when the instruction needs one. It serves array reads through a valid/ready byte-read port and serves status reads from a status input. It keeps the write-enable latch itself. Write data bytes go out on a valid/ready write port, and a transaction-end pulse goes to a separate write controller. That controller owns programming timing, block protection and the array itself.

Serial output data changes only after a falling serial clock edge. The output enable stays low whenever the part is not returning data. On the read-request port a request stays asserted, with a stable address, until the memory accepts it, and the memory returns the byte exactly one cycle after acceptance. The byte must come back before the next byte boundary on the serial link. On the write port a byte stays valid and stable until it is accepted, and it must be accepted before the next byte finishes arriving.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset `wel` and `sdo_oe` are 0, and both ports are idle. `sdo_oe` is 0 while chip select is high and during the instruction and address bits. Serial input is taken on rising serial clock edges, and `sdo` changes only after falling edges.
- R2: READ (0x03) is followed by a 16-bit address, MSB first, of which only the low 10 bits are used. The byte at that address is then shifted out MSB first, starting on the falling edge that follows the last address bit.
- R3: While clocks continue in a read, bytes come out from consecutive addresses, and address 0x3FF is followed by 0x000.
- R4: RDSR (0x05) returns the status byte repeatedly for as long as clocks continue. Its layout is bit 7 protect-enable, bits 6..4 zero, bits 3..2 the block-protect pair, bit 1 `wel`, bit 0 busy. It is served while busy is high.
- R5: A READ decoded while `busy_i` is high makes no read request, and `sdo_oe` stays 0 until chip select rises.
- R6: WREN (0x06) sets `wel` only when chip select rises right after exactly its eight bits. Any further clock before the rise, or busy being high when the instruction is decoded, leaves `wel` unchanged.
- R7: WRDI (0x04) clears `wel` once its eighth bit has been taken in, and a one-cycle pulse on `wel_clr_i` clears `wel` too.
- R8: WRITE (0x02) takes a 16-bit address and then presents each complete data byte on the write port with its address. The low 4 address bits advance and wrap within the 16-byte page, and the upper bits stay fixed.
- R9: WRSR (0x01) presents its one data byte on the write port with `wr_is_status` set.
- R10: Chip select rising during a WRITE or WRSR gives a one-cycle `wr_end`. `wr_end_ok` is 1 only for a WRITE that ended on a byte boundary after at least one data byte, or for a WRSR with exactly one data byte.
- R11: An undefined opcode gives no output enable, no read request and no write activity until chip select goes high. Chip select going high resets the bit counter and the instruction state, so the next transaction decodes normally.
- R12: Any stall on `rd_ready` leaves the read data unchanged, and a write byte stays valid and stable while `wr_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock (idles low) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the sdo pad (0 = high impedance) |
| busy_i | input | 1 | Internal write cycle in progress |
| wpen_i | input | 1 | Protect-enable status bit |
| bp_i | input | 2 | Block-protect status pair |
| wel_clr_i | input | 1 | Pulse from write controller clearing the latch |
| wel_o | output | 1 | Write-enable latch |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 10 | Read request byte address |
| rd_data | input | 8 | Byte returned one cycle after acceptance |
| wr_valid | output | 1 | Write byte valid |
| wr_ready | input | 1 | Write byte accepted |
| wr_addr | output | 10 | Target address of the write byte |
| wr_data | output | 8 | Write data byte |
| wr_is_status | output | 1 | Byte is a status register write |
| wr_end | output | 1 | Chip select rose on an open write transaction |
| wr_end_ok | output | 1 | Write transaction ended correctly, valid with wr_end |

## Verification
The assertions take for granted that the memory always accepts a request and returns its byte before the next serial byte boundary. They also assume the write controller takes each byte before the next one finishes arriving, and that the serial clock is slow enough for every edge to be seen after synchronization. The stimulus keeps to this with a serial clock period of sixteen system cycles. It stalls the read port for at most three cycles in four and holds write-ready low only across an idle gap between transactions. Chip select and the serial clock are never moved within a few system cycles of each other.

// File: rtl/spi_ee_pkg.sv
`timescale 1ns/1ps
package spi_ee_pkg;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WREN  = 8'h06;

  typedef enum logic [3:0] {
    PH_OPC,     // collecting instruction bits
    PH_ADDR,    // collecting the two address bytes
    PH_RDATA,   // streaming array bytes out
    PH_WDATA,   // collecting array write bytes
    PH_STOUT,   // streaming status bytes out
    PH_STIN,    // collecting the status write byte
    PH_STDONE,  // status byte complete, waiting for deselect
    PH_WREN,    // enable instruction complete, waiting for deselect
    PH_IGN      // discarding until deselect
  } phase_e;
endpackage

// File: rtl/spi_ee_sync.sv
`timescale 1ns/1ps
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sel_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o,
  output logic cs_fall_o,
  output logic sdi_o
);
  // bit 2 = chip select, bit 1 = serial clock, bit 0 = data
  logic [2:0] stg [STAGES];
  logic [2:0] last;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= 3'b100;
        else        stg[i] <= {cs_n_i, sck_i, sdi_i};
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= 3'b100;
        else        stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last <= 3'b100;
    else        last <= stg[STAGES-1];

  always_comb begin
    sel_o      = ~stg[STAGES-1][2];
    sdi_o      = stg[STAGES-1][0];
    sck_rise_o =  stg[STAGES-1][1] & ~last[1] & sel_o;
    sck_fall_o = ~stg[STAGES-1][1] &  last[1] & sel_o;
    cs_rise_o  =  stg[STAGES-1][2] & ~last[2];
    cs_fall_o  = ~stg[STAGES-1][2] &  last[2];
  end
endmodule

// File: rtl/spi_ee_wel.sv
`timescale 1ns/1ps
module spi_ee_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
endmodule

// File: rtl/spi_ee_rdpath.sv
`timescale 1ns/1ps
module spi_ee_rdpath #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              active_i,
  input  logic              stat_mode_i,
  input  logic [7:0]        status_i,
  input  logic              sck_fall_i,
  input  logic              boundary_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [ADDR_W-1:0] ptr;
  logic              await_q;
  logic [7:0]        pre_byte;
  logic [7:0]        sh_out;
  logic [7:0]        load_byte;

  assign load_byte = stat_mode_i ? status_i : pre_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; await_q <= 1'b0; pre_byte <= '0; sh_out <= '0;
      rd_valid_o <= 1'b0; rd_addr_o <= '0; sdo_o <= 1'b0; sdo_oe_o <= 1'b0;
    end else if (clear_i) begin
      rd_valid_o <= 1'b0; await_q <= 1'b0; sdo_oe_o <= 1'b0;
    end else begin
      if (await_q) begin
        pre_byte <= rd_data_i;
        await_q  <= 1'b0;
      end
      if (rd_valid_o && rd_ready_i) begin
        rd_valid_o <= 1'b0;
        await_q    <= 1'b1;
        ptr        <= ptr + 1'b1;   // natural wrap at the top of the array
      end
      if (start_i) begin
        rd_valid_o <= 1'b1;
        rd_addr_o  <= start_addr_i;
        ptr        <= start_addr_i;
      end
      if (sck_fall_i && active_i) begin
        if (boundary_i) begin
          sh_out   <= load_byte;
          sdo_o    <= load_byte[7];
          sdo_oe_o <= 1'b1;
          if (!stat_mode_i) begin
            rd_valid_o <= 1'b1;
            rd_addr_o  <= ptr;
          end
        end else begin
          sh_out <= {sh_out[6:0], 1'b0};
          sdo_o  <= sh_out[6];
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !clear_i) |=> (rd_valid_o && $stable(rd_addr_o))) // R12
    else $error("read request dropped");
  AST_PREFETCH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_fall_i && active_i && boundary_i && !stat_mode_i && !clear_i) |-> (!rd_valid_o && !await_q)) // R3
    else $error("byte boundary reached before prefetch finished");
endmodule

// File: rtl/spi_eeprom_engine.sv
`timescale 1ns/1ps
module spi_eeprom_engine #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              busy_i,
  input  logic              wpen_i,
  input  logic [1:0]        bp_i,
  input  logic              wel_clr_i,
  output logic              wel_o,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_is_status,
  output logic              wr_end,
  output logic              wr_end_ok
);
  import spi_ee_pkg::*;

  localparam int SER_ADDR_W = 16;

  logic sel, sck_rise, sck_fall, cs_rise, cs_fall, sdi_s;
  phase_e phase;
  logic [2:0] bit_idx;
  logic [7:0] sh_in, nxt;
  logic [SER_ADDR_W-1:0] addr_sh;
  logic addr_hi, op_read, wr_open, wdata_seen, rd_start;
  logic [ADDR_W-1:0] wr_ptr;
  logic byte_done, wel_set, wel_drop, end_good;
  logic [7:0] status_byte;

  spi_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sel_o(sel), .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_rise_o(cs_rise), .cs_fall_o(cs_fall), .sdi_o(sdi_s)
  );

  assign nxt       = {sh_in[6:0], sdi_s};
  assign byte_done = sck_rise && (bit_idx == 3'd7);
  assign wel_set   = cs_rise && (phase == PH_WREN);
  assign wel_drop  = byte_done && (phase == PH_OPC) && (nxt == OPC_WRDI);
  assign end_good  = (phase == PH_STDONE) ||
                     ((phase == PH_WDATA) && wdata_seen && (bit_idx == 3'd0));
  assign status_byte = {wpen_i, 3'b000, bp_i, wel_o, busy_i};

  spi_ee_wel u_wel (
    .clk(clk), .rst_n(rst_n), .set_i(wel_set),
    .clr_i(wel_drop | wel_clr_i), .wel_o(wel_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OPC; bit_idx <= '0; sh_in <= '0; addr_sh <= '0;
      addr_hi <= 1'b0; op_read <= 1'b0; wr_open <= 1'b0; wdata_seen <= 1'b0;
      rd_start <= 1'b0; wr_ptr <= '0; wr_valid <= 1'b0; wr_addr <= '0;
      wr_data <= '0; wr_is_status <= 1'b0; wr_end <= 1'b0; wr_end_ok <= 1'b0;
    end else begin
      rd_start <= 1'b0;
      wr_end   <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (cs_rise || cs_fall) begin
        if (cs_rise && wr_open) begin
          wr_end    <= 1'b1;
          wr_end_ok <= end_good;
        end
        phase <= PH_OPC; bit_idx <= '0; addr_hi <= 1'b0;
        wr_open <= 1'b0; wdata_seen <= 1'b0;
      end else if (sck_rise) begin
        sh_in   <= nxt;
        bit_idx <= bit_idx + 1'b1;
        unique case (phase)
          PH_OPC: if (byte_done) begin
            unique case (nxt)
              OPC_READ:  begin phase <= busy_i ? PH_IGN : PH_ADDR; op_read <= 1'b1; end
              OPC_WRITE: begin phase <= PH_ADDR; op_read <= 1'b0; wr_open <= 1'b1; end
              OPC_RDSR:  phase <= PH_STOUT;
              OPC_WRSR:  begin phase <= PH_STIN; wr_open <= 1'b1; end
              OPC_WREN:  phase <= busy_i ? PH_IGN : PH_WREN;
              default:   phase <= PH_IGN;
            endcase
          end
          PH_ADDR: begin
            addr_sh <= {addr_sh[SER_ADDR_W-2:0], sdi_s};
            if (byte_done) begin
              addr_hi <= ~addr_hi;
              if (addr_hi) begin
                if (op_read) begin
                  phase    <= PH_RDATA;
                  rd_start <= 1'b1;
                end else begin
                  phase  <= PH_WDATA;
                  wr_ptr <= {addr_sh[ADDR_W-2:0], sdi_s};
                end
              end
            end
          end
          PH_WDATA: if (byte_done) begin
            wr_valid     <= 1'b1;
            wr_data      <= nxt;
            wr_addr      <= wr_ptr;
            wr_is_status <= 1'b0;
            wdata_seen   <= 1'b1;
            wr_ptr       <= {wr_ptr[ADDR_W-1:PAGE_W], wr_ptr[PAGE_W-1:0] + 1'b1};
          end
          PH_STIN: if (byte_done) begin
            wr_valid     <= 1'b1;
            wr_data      <= nxt;
            wr_addr      <= '0;
            wr_is_status <= 1'b1;
            phase        <= PH_STDONE;
          end
          PH_WREN, PH_STDONE: phase <= PH_IGN;
          default: ;
        endcase
      end
    end
  end

  spi_ee_rdpath #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .clear_i(cs_rise | cs_fall),
    .start_i(rd_start), .start_addr_i(addr_sh[ADDR_W-1:0]),
    .active_i((phase == PH_RDATA) || (phase == PH_STOUT)),
    .stat_mode_i(phase == PH_STOUT), .status_i(status_byte),
    .sck_fall_i(sck_fall), .boundary_i(bit_idx == 3'd0),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OPC) |-> !sdo_oe) // R1
    else $error("output enabled outside a data phase");
  AST_NO_FETCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |-> !rd_valid) // R5
    else $error("read request while discarding");
  AST_WEL_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_o) |-> $past(cs_rise)) // R6
    else $error("write enable latch set without chip select rising");
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> (bit_idx == 3'd0 && phase == PH_OPC)) // R11
    else $error("instruction state not cleared on deselect");
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr))) // R12
    else $error("write byte changed while stalled");
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_end |=> !wr_end) // R10
    else $error("end pulse longer than a cycle");
endmodule

// File: tb/spi_eeprom_engine_tb.sv
`timescale 1ns/1ps
module spi_eeprom_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  logic busy = 1'b0, wpen = 1'b0, wel_clr = 1'b0;
  logic [1:0] bp = 2'b00;
  logic wel;
  logic rd_valid, rd_ready;
  logic [9:0] rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic wr_valid, wr_ready = 1'b1;
  logic [9:0] wr_addr;
  logic [7:0] wr_data;
  logic wr_is_status, wr_end, wr_end_ok;

  int total = 0, bad = 0;
  int rd_cnt = 0, wb_n = 0, end_n = 0;
  logic end_ok_last = 1'b0;
  logic [9:0] wb_addr [16];
  logic [7:0] wb_data [16];
  logic       wb_st   [16];
  logic       stall_en = 1'b0;
  logic [1:0] stall_cnt = 2'b00;
  logic       done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  spi_eeprom_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy_i(busy), .wpen_i(wpen), .bp_i(bp),
    .wel_clr_i(wel_clr), .wel_o(wel), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_is_status(wr_is_status),
    .wr_end(wr_end), .wr_end_ok(wr_end_ok)
  );

  function automatic logic [7:0] memf(input logic [9:0] a);
    return (a[7:0] + {a[9:8], 6'd0}) ^ 8'h5A;
  endfunction

  assign rd_ready = !stall_en || (stall_cnt == 2'd0);

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 2'd1;
    if (rd_valid && rd_ready) begin
      rd_cnt  <= rd_cnt + 1;
      rd_data <= memf(rd_addr);
    end
    if (wr_valid && wr_ready) begin
      wb_addr[wb_n % 16] <= wr_addr;
      wb_data[wb_n % 16] <= wr_data;
      wb_st[wb_n % 16]   <= wr_is_status;
      wb_n <= wb_n + 1;
    end
    if (wr_end) begin
      end_n <= end_n + 1;
      end_ok_last <= wr_end_ok;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic align();
    @(negedge clk); #1;
  endtask

  task automatic sel_lo();
    align(); cs_n = 1'b0; #40;
  endtask

  task automatic sel_hi();
    #40; cs_n = 1'b1; #120;
  endtask

  task automatic spi_bit(input logic b, output logic r, output logic oe);
    sdi = b; #30; r = sdo; oe = sdo_oe; #2;
    sck = 1'b1; #32; sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
    logic r, oe;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], r, oe);
      rx[i] = r;
      oe_all = oe_all & oe;
    end
  endtask

  task automatic spi_cmd_addr(input logic [7:0] op, input logic [15:0] a, output logic oe_any);
    logic [7:0] rx; logic oe;
    spi_byte(op, rx, oe);      oe_any = oe;
    spi_byte(a[15:8], rx, oe); oe_any = oe_any | oe;
    spi_byte(a[7:0], rx, oe);  oe_any = oe_any | oe;
  endtask

  task automatic t_reset();
    chk(sdo_oe == 1'b0, "R1 reset oe", sdo_oe, 0);
    chk(wel == 1'b0, "R1 reset wel", wel, 0);
    chk(rd_valid == 1'b0 && wr_valid == 1'b0, "R1 reset ports", {rd_valid, wr_valid}, 0);
  endtask

  task automatic t_read(input logic [15:0] a, input int n, input string tag);
    logic [7:0] rx; logic oe, oe_any;
    logic [9:0] p;
    p = a[9:0];
    sel_lo();
    spi_cmd_addr(8'h03, a, oe_any);
    chk(oe_any == 1'b0, {tag, " R1 oe low in header"}, oe_any, 0);
    for (int k = 0; k < n; k++) begin
      spi_byte(8'h00, rx, oe);
      chk(rx == memf(p), tag, rx, memf(p));
      chk(oe == 1'b1, {tag, " R1 oe during data"}, oe, 1);
      p = p + 10'd1;
    end
    sel_hi();
    chk(sdo_oe == 1'b0, {tag, " R1 oe after deselect"}, sdo_oe, 0);
  endtask

  task automatic t_rdsr(input logic [7:0] exp, input string tag);
    logic [7:0] rx; logic oe;
    sel_lo();
    spi_byte(8'h05, rx, oe);
    for (int k = 0; k < 2; k++) begin
      spi_byte(8'h00, rx, oe);
      chk(rx == exp && oe, tag, rx, exp);
    end
    sel_hi();
  endtask

  task automatic t_read_busy();
    logic [7:0] rx; logic oe, oe_any; int c0;
    busy = 1'b1; c0 = rd_cnt;
    sel_lo();
    spi_cmd_addr(8'h03, 16'h0040, oe_any);
    spi_byte(8'h00, rx, oe);
    chk(oe == 1'b0 && oe_any == 1'b0, "R5 oe stays low when busy", oe, 0);
    sel_hi();
    chk(rd_cnt == c0, "R5 no read request when busy", rd_cnt - c0, 0);
    busy = 1'b0;
  endtask

  task automatic opcode_only(input logic [7:0] op);
    logic [7:0] rx; logic oe;
    sel_lo(); spi_byte(op, rx, oe); sel_hi();
  endtask

  task automatic t_wel();
    logic [7:0] rx; logic oe, r;
    opcode_only(8'h06);
    chk(wel == 1'b1, "R6 wel set by clean WREN", wel, 1);
    opcode_only(8'h04);
    chk(wel == 1'b0, "R7 WRDI clears wel", wel, 0);
    sel_lo(); spi_byte(8'h06, rx, oe); spi_bit(1'b0, r, oe); sel_hi();
    chk(wel == 1'b0, "R6 extra clock blocks WREN", wel, 0);
    sel_lo(); spi_byte(8'h06, rx, oe); spi_byte(8'h05, rx, oe); sel_hi();
    chk(wel == 1'b0, "R6 second instruction blocks WREN", wel, 0);
    busy = 1'b1; opcode_only(8'h06); busy = 1'b0;
    chk(wel == 1'b0, "R6 WREN ignored while busy", wel, 0);
    opcode_only(8'h06);
    align(); wel_clr = 1'b1; @(negedge clk); wel_clr = 1'b0; #1;
    chk(wel == 1'b0, "R7 clear pulse drops wel", wel, 0);
  endtask

  task automatic t_write();
    logic [7:0] rx; logic oe, oe_any; int w0, e0;
    logic [7:0] dat [4];
    logic [9:0] ea  [4];
    dat[0] = 8'h11; dat[1] = 8'h22; dat[2] = 8'h33; dat[3] = 8'h44;
    ea[0] = 10'h12E; ea[1] = 10'h12F; ea[2] = 10'h120; ea[3] = 10'h121;
    w0 = wb_n; e0 = end_n;
    sel_lo();
    spi_cmd_addr(8'h02, 16'hFD2E, oe_any);
    for (int k = 0; k < 4; k++) spi_byte(dat[k], rx, oe);
    sel_hi();
    chk(wb_n - w0 == 4, "R8 four bytes forwarded", wb_n - w0, 4);
    for (int k = 0; k < 4; k++) begin
      chk(wb_addr[(w0 + k) % 16] == ea[k] && wb_data[(w0 + k) % 16] == dat[k]
          && !wb_st[(w0 + k) % 16], "R8 byte address with page wrap",
          wb_addr[(w0 + k) % 16], ea[k]);
    end
    chk(end_n - e0 == 1 && end_ok_last, "R10 aligned write ends ok", end_ok_last, 1);
  endtask

  task automatic t_write_partial();
    logic [7:0] rx; logic oe, oe_any, r; int e0;
    e0 = end_n;
    sel_lo();
    spi_cmd_addr(8'h02, 16'h0000, oe_any);
    spi_byte(8'h55, rx, oe);
    for (int k = 0; k < 3; k++) spi_bit(1'b1, r, oe);
    sel_hi();
    chk(end_n - e0 == 1 && !end_ok_last, "R10 misaligned write not ok", end_ok_last, 0);
  endtask

  task automatic t_wrsr();
    logic [7:0] rx; logic oe; int w0, e0;
    w0 = wb_n; e0 = end_n;
    sel_lo(); spi_byte(8'h01, rx, oe); spi_byte(8'h8C, rx, oe); sel_hi();
    chk(wb_n - w0 == 1 && wb_data[w0 % 16] == 8'h8C && wb_st[w0 % 16],
        "R9 status byte forwarded", wb_data[w0 % 16], 8'h8C);
    chk(end_n - e0 == 1 && end_ok_last, "R10 single status byte ok", end_ok_last, 1);
    sel_lo(); spi_byte(8'h01, rx, oe); spi_byte(8'h0C, rx, oe); spi_byte(8'h00, rx, oe); sel_hi();
    chk(end_n - e0 == 2 && !end_ok_last, "R10 extra status byte not ok", end_ok_last, 0);
  endtask

  task automatic t_undef();
    logic [7:0] rx; logic oe, oe_any; int c0, w0, e0;
    c0 = rd_cnt; w0 = wb_n; e0 = end_n; oe_any = 1'b0;
    sel_lo();
    spi_byte(8'hA5, rx, oe); oe_any = oe_any | oe;
    spi_byte(8'h03, rx, oe); oe_any = oe_any | oe;
    spi_byte(8'h00, rx, oe); oe_any = oe_any | oe;
    spi_byte(8'h00, rx, oe); oe_any = oe_any | oe;
    sel_hi();
    chk(!oe_any && rd_cnt == c0 && wb_n == w0 && end_n == e0,
        "R11 undefined opcode silent", {oe_any, 8'(rd_cnt - c0)}, 0);
  endtask

  task automatic t_wr_stall();
    logic [7:0] rx; logic oe, oe_any; int w0;
    w0 = wb_n;
    align(); wr_ready = 1'b0;
    sel_lo(); spi_cmd_addr(8'h02, 16'h0200, oe_any); spi_byte(8'h77, rx, oe); sel_hi();
    chk(wr_valid && wr_data == 8'h77 && wr_addr == 10'h200, "R12 byte held while stalled",
        wr_data, 8'h77);
    align(); wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr_valid && wb_n - w0 == 1 && wb_data[w0 % 16] == 8'h77,
        "R12 byte taken once after stall", wb_n - w0, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read(16'hFD23, 3, "R2 read with don't-care bits");
    t_read(16'h03FE, 4, "R3 read wraps past top");
    wpen = 1'b1; bp = 2'b10; busy = 1'b1;
    t_rdsr(8'h89, "R4 status while busy");
    busy = 1'b0; wpen = 1'b0; bp = 2'b01;
    opcode_only(8'h06);
    t_rdsr(8'h06, "R4 status shows wel");
    opcode_only(8'h04);
    t_read_busy();
    t_wel();
    t_write();
    t_write_partial();
    t_wrsr();
    t_undef();
    t_read(16'h0155, 2, "R11 decode after ignored opcode");
    stall_en = 1'b1;
    t_read(16'h00F0, 3, "R12 read under request stall");
    stall_en = 1'b0;
    t_wr_stall();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule